// File: doc/BRIEF.md
# Prioritized Locality Ownership Arbiter

This block decides which of five numbered localities (0 to 4) owns a shared secure device at any moment. Each locality issues command writes that a bus decoder outside this block has already turned into a one-cycle pulse. The pulse carries the locality number and four command bits: ask for access, give up ownership, take ownership by force, and clear the establishment flag. The block keeps the current owner, a queue of waiting requests, one sticky "taken away" flag per locality and a platform establishment flag. It presents them as one shared 8-bit state word and a 2-bit status field per locality.

A higher number means higher priority. A locality can take ownership by force only from a lower-numbered owner. When the owner gives up ownership, the device passes to the highest-numbered locality that is waiting. Only localities 3 and 4 may clear the establishment flag. An external end-of-measurement pulse sets it again.

Top module: `loc_owner_arb`

## Requirements
- R1: While reset is held, state_reg reads 0x01. From the first clock edge after reset is released, bit 7 (valid) reads 1 and stays 1, so the idle word is 0x81 and every loc_status bit is 0.
- R2: state_reg layout: bit 7 valid, bits 6:5 zero, bits 4:2 the active locality number, bit 1 assigned, bit 0 establishment. When no locality is assigned, a request (wr_ctrl bit 0) grants the requester on the next edge. loc_status bit 2*i is the granted flag of locality i, and at most one granted flag is set.
- R3: A request from a non-owner while another locality owns the device is queued and does not change the owner.
- R4: A relinquish (wr_ctrl bit 1) from the owner hands ownership to the highest-numbered queued locality. If nothing is queued, assigned and the active field both become 0.
- R5: A seize (wr_ctrl bit 2) succeeds only while a locality is assigned and the seizer's number is greater than the owner's. The seizer then becomes owner, and the old owner's flag at loc_status bit 2*i+1 is set. An equal, lower or unassigned seize has no effect.
- R6: A locality's seized flag stays set until that locality issues its next request.
- R7: A reset-establishment write (wr_ctrl bit 3) from locality 3 or 4 clears state_reg bit 0. The same write from localities 0 to 2 leaves it unchanged.
- R8: A hash_end pulse sets state_reg bit 0 on the next edge, and it wins over a reset-establishment write in the same cycle.
- R9: Within one write, seize takes precedence over relinquish, and relinquish over request. Reset-establishment acts independently of these. A write tagged with locality 5, 6 or 7 has no effect.
- R10: A relinquish from a locality that is not the owner withdraws its queued request and leaves the owner unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle command write strobe |
| wr_loc | input | 3 | Issuing locality number |
| wr_ctrl | input | 4 | Command bits: 0 request, 1 relinquish, 2 seize, 3 reset-establishment |
| hash_end | input | 1 | End-of-measurement pulse, sets the establishment flag |
| state_reg | output | 8 | Shared state word |
| loc_status | output | 10 | Per locality i: bit 2i granted, bit 2i+1 seized |

## Verification
The bench goes after the hand-over order on relinquish. A design that granted the queue in arrival order or to the lowest number would hand the device to locality 0 or 2 instead of 3. It probes seizes from equal and lower localities and with no owner, which a loose comparison would wrongly accept. It checks that the seized flag survives the victim's loss of the device and clears only on that locality's request. It also covers a same-cycle hash_end and clear, multi-bit writes, and out-of-range locality tags, where a wrong precedence or a missing range check would move ownership.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int NLOC_DEF  = 5;
  localparam int LOC_W_DEF = 3;

  // Highest set index of a request vector (0 when empty).
  function automatic logic [LOC_W_DEF-1:0] top_index(input logic [NLOC_DEF-1:0] v);
    logic [LOC_W_DEF-1:0] idx;
    idx = '0;
    for (int i = 0; i < NLOC_DEF; i++)
      if (v[i]) idx = LOC_W_DEF'(i);
    return idx;
  endfunction

  // Shared state word: valid, two zero bits, active locality, assigned, established.
  function automatic logic [7:0] pack_state(input logic vld, input logic [LOC_W_DEF-1:0] loc,
                                            input logic asg, input logic est);
    return {vld, 2'b00, (asg ? loc : '0), asg, est};
  endfunction
endpackage

// File: rtl/loc_cmd_decode.sv
module loc_cmd_decode #(
  parameter int NLOC        = loc_arb_pkg::NLOC_DEF,
  parameter int LOC_W       = loc_arb_pkg::LOC_W_DEF,
  parameter int EST_MIN_LOC = 3
) (
  input  logic             wr_valid,
  input  logic [LOC_W-1:0] wr_loc,
  input  logic [3:0]       wr_ctrl,
  output logic             do_seize,
  output logic             do_rel,
  output logic             do_req,
  output logic             do_rst_est
);
  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NLOC - 1);
  localparam logic [LOC_W-1:0] EST_LOC  = LOC_W'(EST_MIN_LOC);

  logic loc_ok;
  assign loc_ok     = wr_valid && (wr_loc <= LAST_LOC);
  assign do_seize   = loc_ok && wr_ctrl[2];
  assign do_rel     = loc_ok && !wr_ctrl[2] && wr_ctrl[1];
  assign do_req     = loc_ok && !wr_ctrl[2] && !wr_ctrl[1] && wr_ctrl[0];
  assign do_rst_est = loc_ok && wr_ctrl[3] && (wr_loc >= EST_LOC);
endmodule

// File: rtl/loc_owner_core.sv
module loc_owner_core #(
  parameter int NLOC  = loc_arb_pkg::NLOC_DEF,
  parameter int LOC_W = loc_arb_pkg::LOC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] wr_loc,
  input  logic             do_seize,
  input  logic             do_rel,
  input  logic             do_req,
  output logic [LOC_W-1:0] own_q,
  output logic             asg_q,
  output logic [NLOC-1:0]  seized_q,
  output logic             seize_ok,
  output logic             rel_own,
  output logic             req_grant
);
  logic [NLOC-1:0]  pend_q, pend_n, seized_n, loc_bit;
  logic [LOC_W-1:0] own_n;
  logic             asg_n, is_owner;

  assign loc_bit   = NLOC'(1) << wr_loc;
  assign is_owner  = asg_q && (wr_loc == own_q);
  assign seize_ok  = do_seize && asg_q && (wr_loc > own_q);
  assign rel_own   = do_rel && is_owner;
  assign req_grant = do_req && !asg_q;

  always_comb begin
    own_n    = own_q;
    asg_n    = asg_q;
    pend_n   = pend_q;
    seized_n = seized_q;
    if (seize_ok) begin
      seized_n = seized_q | (NLOC'(1) << own_q);
      own_n    = wr_loc;
      pend_n   = pend_q & ~loc_bit;
    end else if (rel_own) begin
      if (pend_q != '0) begin
        own_n  = loc_arb_pkg::top_index(pend_q);
        pend_n = pend_q & ~(NLOC'(1) << loc_arb_pkg::top_index(pend_q));
      end else begin
        own_n = '0;
        asg_n = 1'b0;
      end
    end else if (do_rel) begin
      pend_n = pend_q & ~loc_bit;
    end else if (do_req) begin
      seized_n = seized_q & ~loc_bit;
      if (req_grant) begin
        own_n = wr_loc;
        asg_n = 1'b1;
      end else if (!is_owner) begin
        pend_n = pend_q | loc_bit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q    <= '0;
      asg_q    <= 1'b0;
      pend_q   <= '0;
      seized_q <= '0;
    end else begin
      own_q    <= own_n;
      asg_q    <= asg_n;
      pend_q   <= pend_n;
      seized_q <= seized_n;
    end
  end
endmodule

// File: rtl/loc_est_flag.sv
module loc_est_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic est_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   est_q <= 1'b1;
    else if (set) est_q <= 1'b1;
    else if (clr) est_q <= 1'b0;
  end
endmodule

// File: rtl/loc_owner_arb.sv
module loc_owner_arb #(
  parameter int NLOC  = loc_arb_pkg::NLOC_DEF,
  parameter int LOC_W = loc_arb_pkg::LOC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [LOC_W-1:0] wr_loc,
  input  logic [3:0]       wr_ctrl,
  input  logic             hash_end,
  output logic [7:0]       state_reg,
  output logic [2*NLOC-1:0] loc_status
);
  logic             do_seize, do_rel, do_req, do_rst_est;
  logic [LOC_W-1:0] own_q;
  logic             asg_q, est_q, vld_q;
  logic [NLOC-1:0]  seized_q;
  logic             seize_ok, rel_own, req_grant;

  loc_cmd_decode #(.NLOC(NLOC), .LOC_W(LOC_W)) u_dec (
    .wr_valid(wr_valid), .wr_loc(wr_loc), .wr_ctrl(wr_ctrl),
    .do_seize(do_seize), .do_rel(do_rel), .do_req(do_req), .do_rst_est(do_rst_est)
  );

  loc_owner_core #(.NLOC(NLOC), .LOC_W(LOC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_loc(wr_loc),
    .do_seize(do_seize), .do_rel(do_rel), .do_req(do_req),
    .own_q(own_q), .asg_q(asg_q), .seized_q(seized_q),
    .seize_ok(seize_ok), .rel_own(rel_own), .req_grant(req_grant)
  );

  loc_est_flag u_est (
    .clk(clk), .rst_n(rst_n), .clr(do_rst_est), .set(hash_end), .est_q(est_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= 1'b1;
  end

  assign state_reg = loc_arb_pkg::pack_state(vld_q, own_q, asg_q, est_q);

  for (genvar i = 0; i < NLOC; i++) begin : g_status
    assign loc_status[2*i]   = asg_q && (own_q == LOC_W'(i));
    assign loc_status[2*i+1] = seized_q[i];
  end
endmodule

// File: rtl/loc_owner_arb_chk.sv
module loc_owner_arb_chk #(
  parameter int NLOC  = 5,
  parameter int LOC_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [LOC_W-1:0]  wr_loc,
  input logic              hash_end,
  input logic [7:0]        state_reg,
  input logic [2*NLOC-1:0] loc_status,
  input logic              seize_ok,
  input logic              rel_own,
  input logic              req_grant
);
  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NLOC - 1);
  logic [NLOC-1:0] granted, seized;
  always_comb
    for (int i = 0; i < NLOC; i++) begin
      granted[i] = loc_status[2*i];
      seized[i]  = loc_status[2*i+1];
    end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(granted)); // R2
  AST_REQ_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    req_grant |=> state_reg[1] && (state_reg[4:2] == $past(wr_loc))); // R2
  AST_UNASSIGNED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !state_reg[1] |-> (state_reg[4:2] == '0) && (granted == '0)); // R4
  AST_REL_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    rel_own |=> !granted[$past(state_reg[4:2])]); // R4
  AST_SEIZE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    seize_ok |=> seized[$past(state_reg[4:2])] && (state_reg[4:2] > $past(state_reg[4:2]))); // R5
  AST_LOW_EST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_loc < 3'd3 && !hash_end) |=> $stable(state_reg[0])); // R7
  AST_HASH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hash_end |=> state_reg[0]); // R8
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state_reg[7] |=> state_reg[7]); // R1
  AST_BAD_LOC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_reg[7] && wr_valid && wr_loc > LAST_LOC && !hash_end) |=>
      $stable(state_reg) && $stable(loc_status)); // R9
endmodule

bind loc_owner_arb loc_owner_arb_chk #(.NLOC(NLOC), .LOC_W(LOC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_loc(wr_loc), .hash_end(hash_end),
  .state_reg(state_reg), .loc_status(loc_status),
  .seize_ok(seize_ok), .rel_own(rel_own), .req_grant(req_grant)
);

// File: tb/loc_owner_arb_tb.sv
module loc_owner_arb_tb;
  localparam logic [3:0] REQ = 4'b0001, REL = 4'b0010, SZ = 4'b0100, EST = 4'b1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [2:0] wr_loc = '0;
  logic [3:0] wr_ctrl = '0;
  logic       hash_end = 1'b0;
  logic [7:0] state_reg;
  logic [9:0] loc_status;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  loc_owner_arb u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_loc(wr_loc),
    .wr_ctrl(wr_ctrl), .hash_end(hash_end), .state_reg(state_reg), .loc_status(loc_status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive one write for one cycle; returns at the negedge after the capturing edge.
  task automatic wr(input logic [2:0] loc, input logic [3:0] ctrl, input logic he = 1'b0);
    wr_valid = 1'b1; wr_loc = loc; wr_ctrl = ctrl; hash_end = he;
    @(negedge clk);
    wr_valid = 1'b0; wr_ctrl = '0; hash_end = 1'b0;
  endtask

  task automatic pulse_hash();
    hash_end = 1'b1;
    @(negedge clk);
    hash_end = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 state in reset", state_reg, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after reset", state_reg, 8'h81);
    chk("R1 status after reset", loc_status, 10'h000);
  endtask

  task automatic t_request_idle();
    wr(3'd1, REQ);
    chk("R2 grant state", state_reg, 8'h87);
    chk("R2 grant status", loc_status, 10'h004);
  endtask

  task automatic t_queue_relinquish();
    wr(3'd0, REQ); wr(3'd3, REQ); wr(3'd2, REQ);
    chk("R3 owner kept", state_reg, 8'h87);
    chk("R3 status kept", loc_status, 10'h004);
    wr(3'd1, REL);
    chk("R4 highest queued gets it", state_reg, 8'h8F);
    chk("R4 status loc3", loc_status, 10'h040);
    wr(3'd3, REL);
    chk("R4 next highest", state_reg, 8'h8B);
    wr(3'd0, REL);
    chk("R10 non-owner relinquish", state_reg, 8'h8B);
    wr(3'd2, REL);
    chk("R10 withdrawn, R4 empty queue", state_reg, 8'h81);
    chk("R4 status empty", loc_status, 10'h000);
  endtask

  task automatic t_seize();
    wr(3'd2, SZ);
    chk("R5 seize unassigned ignored", state_reg, 8'h81);
    wr(3'd2, REQ);
    wr(3'd1, SZ);
    chk("R5 lower seize ignored", state_reg, 8'h8B);
    wr(3'd2, SZ);
    chk("R5 equal seize ignored", loc_status, 10'h010);
    wr(3'd4, SZ);
    chk("R5 seize state", state_reg, 8'h93);
    chk("R5 seize status", loc_status, 10'h120);
  endtask

  task automatic t_sticky();
    wr(3'd4, REL);
    chk("R6 flag survives", loc_status, 10'h020);
    chk("R6 unassigned", state_reg, 8'h81);
    wr(3'd2, REQ);
    chk("R6 cleared by request", loc_status, 10'h010);
  endtask

  task automatic t_est();
    wr(3'd2, EST);
    chk("R7 low locality ignored", state_reg, 8'h8B);
    wr(3'd3, EST);
    chk("R7 loc3 clears", state_reg, 8'h8A);
    pulse_hash();
    chk("R8 hash sets", state_reg, 8'h8B);
    wr(3'd4, EST, 1'b1);
    chk("R8 hash wins", state_reg, 8'h8B);
    wr(3'd4, EST);
    chk("R7 loc4 clears", state_reg, 8'h8A);
    pulse_hash();
    chk("R8 hash sets again", state_reg, 8'h8B);
  endtask

  task automatic t_priority_invalid();
    wr(3'd5, SZ | REQ);
    chk("R9 loc5 ignored state", state_reg, 8'h8B);
    chk("R9 loc5 ignored status", loc_status, 10'h010);
    wr(3'd6, EST);
    chk("R9 loc6 est ignored", state_reg, 8'h8B);
    wr(3'd3, SZ | REL | REQ);
    chk("R9 seize first state", state_reg, 8'h8F);
    chk("R9 seize first status", loc_status, 10'h060);
    wr(3'd3, REL | REQ);
    chk("R9 relinquish over request", state_reg, 8'h81);
    wr(3'd0, REQ | EST);
    chk("R9 request with low est", state_reg, 8'h83);
    chk("R9 status loc0", loc_status, 10'h021);
  endtask

  initial begin
    t_reset();
    t_request_idle();
    t_queue_relinquish();
    t_seize();
    t_sticky();
    t_est();
    t_priority_invalid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule